// File: doc/BRIEF.md
# Multi-Level Feature Threshold Encoder

This block turns a stream of signed fixed-point feature values, one image's worth at a time, into a packed vector of two-bit level codes for a downstream hyperdimensional stage. Every feature index owns three private thresholds. Thresholds are held in an on-block configuration store that is written before images arrive. A feature's level is the number of its own thresholds that it reaches. Raw values are compared directly, with no scaling or normalization ahead of the comparators.

Features enter with a valid strobe at a rate of up to one per clock. The block counts them by arrival order. When the last feature of the vector has been graded, a done flag goes high. The flag stays high, and the code vector stays frozen, until the first feature of the next image is accepted.

Top module: `feat_level_encoder`

## Requirements
- R1: Reset (synchronous, active high) clears `codes` to all zeros and drives `done` low.
- R2: A feature's code is the count of its three thresholds that are less than or equal to the feature value, with both read as two's-complement signed numbers. A value equal to a threshold therefore takes the higher level. The code runs from 0 (below every threshold) to 3 (at or above all three).
- R3: The code of the feature accepted in position i of an image (counting from 0) is placed in `codes[2*i+1:2*i]`, so feature 0 sits at the least significant end.
- R4: A configuration write stores `cfg_thr` into the threshold selected by `cfg_addr`. The upper address bits hold the feature index and the two low bits hold the threshold number 0, 1 or 2. A write with threshold number 3 changes no threshold.
- R5: `done` rises at the clock edge one cycle after the edge that accepts the last feature of an image. With valid held high throughout, that is N edges after the edge that accepts the first feature, where N is the feature count.
- R6: Once high, `done` and `codes` hold their values while no feature is presented. `done` falls at the edge that accepts the first feature of the next image.
- R7: A valid strobe in the one cycle immediately after the last feature of an image is ignored. It is neither graded nor counted toward the next image.
- R8: Cycles with valid low are skipped. The feature position advances only on accepted features, so gaps between features do not change the codes.
- R9: Thresholds rewritten between images apply to every image that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_addr | input | IDX_W+2 | Write address: feature index above, threshold number in bits [1:0] |
| cfg_thr | input | FEAT_W | Signed threshold value to store |
| feat_valid | input | 1 | Feature strobe |
| feat_data | input | FEAT_W | Signed feature value |
| done | output | 1 | Whole vector graded; held until the next image starts |
| codes | output | 2*NUM_FEAT | Packed level codes, feature 0 at the LSB end |

## Verification
The bench runs a small configuration with eight features of six bits. It drives 64 images, so every feature sees every representable value, from the most negative to the most positive. Against these values, each feature's thresholds are chosen to include:
- duplicated thresholds, which separate the at-or-above rule from a strictly-above rule;
- thresholds pinned at both ends of the range.

Alternating images arrive back-to-back and with one-cycle gaps. This separates position counting by accepted feature from counting by cycle, and it pins the exact edge at which done rises. Further stimuli cover the following:
- a stray strobe during the drain cycle;
- writes to the unused threshold slot;
- mid-stream threshold rewrites.

Each of these would shift, corrupt or stale-load the codes if handled wrongly.

// File: rtl/feq_pkg.sv
package feq_pkg;

  // Sequencing state of the feature counter.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // after reset, nothing encoded yet
    ST_RUN   = 2'd1,  // inside an image
    ST_DRAIN = 2'd2,  // last feature accepted, its code still in flight
    ST_DONE  = 2'd3   // vector complete, waiting for the next image
  } feq_state_e;

endpackage

// File: rtl/feq_thr_mem.sv
// Threshold store: one bank per threshold number, so all thresholds of a
// feature are read together in a single registered access.
module feq_thr_mem #(
  parameter int NUM_FEAT = 64,
  parameter int FEAT_W   = 16,
  parameter int NUM_THR  = 3,
  parameter int IDX_W    = 6,
  parameter int SLOT_W   = 2
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [SLOT_W-1:0]           wr_slot,
  input  logic [FEAT_W-1:0]           wr_val,
  input  logic                        rd_en,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [NUM_THR*FEAT_W-1:0]   rd_thr
);

  for (genvar k = 0; k < NUM_THR; k++) begin : g_bank
    logic [FEAT_W-1:0] bank_q [NUM_FEAT];
    logic              bank_we;

    // Slot numbers beyond the last bank select no bank at all.
    assign bank_we = wr_en && (wr_slot == SLOT_W'(k));

    always_ff @(posedge clk) begin
      if (bank_we) bank_q[wr_idx] <= wr_val;
    end

    always_ff @(posedge clk) begin
      if (rd_en) rd_thr[k*FEAT_W +: FEAT_W] <= bank_q[rd_idx];
    end
  end

endmodule

// File: rtl/feq_ctrl.sv
// Feature sequencer: counts accepted features, blocks the drain cycle and
// owns the done flag.
module feq_ctrl
  import feq_pkg::*;
#(
  parameter int NUM_FEAT = 64,
  parameter int IDX_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             feat_valid,
  output logic             accept,
  output logic             first_acc,
  output logic [IDX_W-1:0] acc_idx,
  output logic             acc_last,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FEAT - 1);

  feq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;

  assign accept    = feat_valid && (state_q != ST_DRAIN);
  assign first_acc = accept && (state_q != ST_RUN);
  assign acc_idx   = (state_q == ST_RUN) ? idx_q : '0;
  assign acc_last  = accept && (acc_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_DRAIN: state_q <= ST_DONE;
        default: begin
          if (accept) begin
            if (acc_last) begin
              state_q <= ST_DRAIN;
              idx_q   <= '0;
            end else begin
              state_q <= ST_RUN;
              idx_q   <= acc_idx + IDX_W'(1);
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    done <= 1'b0;
    else if (state_q == ST_DRAIN) done <= 1'b1;
    else if (first_acc)         done <= 1'b0;
  end

  // R5: the drain cycle always ends with done raised
  a_r5_drain_sets_done: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRAIN) |=> done);

  // R6: done holds while no feature is offered
  a_r6_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !feat_valid) |=> done);

  // R6: done only drops when a new image begins
  a_r6_done_drop_on_start: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(first_acc));

  // R8: an idle cycle never advances the feature position
  a_r8_gap_keeps_index: assert property (@(posedge clk) disable iff (rst)
    !feat_valid |=> $stable(idx_q));

endmodule

// File: rtl/feq_quant.sv
// Level grader: one comparator per threshold, then a count of the hits.
module feq_quant #(
  parameter int FEAT_W  = 16,
  parameter int NUM_THR = 3,
  parameter int CODE_W  = 2
) (
  input  logic signed [FEAT_W-1:0]   feat,
  input  logic [NUM_THR*FEAT_W-1:0]  thr,
  output logic [NUM_THR-1:0]         hit,
  output logic [CODE_W-1:0]          level
);

  function automatic logic [CODE_W-1:0] count_hits(input logic [NUM_THR-1:0] h);
    logic [CODE_W-1:0] n;
    n = '0;
    for (int k = 0; k < NUM_THR; k++) n = n + CODE_W'(h[k]);
    return n;
  endfunction

  for (genvar k = 0; k < NUM_THR; k++) begin : g_cmp
    logic signed [FEAT_W-1:0] t;
    assign t      = thr[k*FEAT_W +: FEAT_W];
    assign hit[k] = (feat >= t);
  end

  assign level = count_hits(hit);

endmodule

// File: rtl/feat_level_encoder.sv
// Top: accept stage (threshold read + feature capture), then grade and pack.
module feat_level_encoder
  import feq_pkg::*;
#(
  parameter int NUM_FEAT = 64,
  parameter int FEAT_W   = 16,
  parameter int NUM_LVL  = 4,
  localparam int NUM_THR = NUM_LVL - 1,
  localparam int CODE_W  = $clog2(NUM_LVL),
  localparam int IDX_W   = (NUM_FEAT > 1) ? $clog2(NUM_FEAT) : 1,
  localparam int SLOT_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int CFG_AW  = IDX_W + SLOT_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [CFG_AW-1:0]          cfg_addr,
  input  logic [FEAT_W-1:0]          cfg_thr,
  input  logic                       feat_valid,
  input  logic [FEAT_W-1:0]          feat_data,
  output logic                       done,
  output logic [NUM_FEAT*CODE_W-1:0] codes
);

  // Sequencer
  logic             accept;
  logic             first_acc;
  logic [IDX_W-1:0] acc_idx;
  logic             acc_last;

  feq_ctrl #(.NUM_FEAT(NUM_FEAT), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .feat_valid (feat_valid),
    .accept     (accept),
    .first_acc  (first_acc),
    .acc_idx    (acc_idx),
    .acc_last   (acc_last),
    .done       (done)
  );

  // Threshold store, read in the accept cycle
  logic [NUM_THR*FEAT_W-1:0] thr_rd;

  feq_thr_mem #(
    .NUM_FEAT (NUM_FEAT),
    .FEAT_W   (FEAT_W),
    .NUM_THR  (NUM_THR),
    .IDX_W    (IDX_W),
    .SLOT_W   (SLOT_W)
  ) u_mem (
    .clk     (clk),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_addr[CFG_AW-1:SLOT_W]),
    .wr_slot (cfg_addr[SLOT_W-1:0]),
    .wr_val  (cfg_thr),
    .rd_en   (accept),
    .rd_idx  (acc_idx),
    .rd_thr  (thr_rd)
  );

  // Accept stage registers
  logic                     s1_valid;
  logic                     s1_last;
  logic [IDX_W-1:0]         s1_idx;
  logic signed [FEAT_W-1:0] s1_feat;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_last  <= 1'b0;
      s1_idx   <= '0;
      s1_feat  <= '0;
    end else begin
      s1_valid <= accept;
      s1_last  <= acc_last;
      if (accept) begin
        s1_idx  <= acc_idx;
        s1_feat <= feat_data;
      end
    end
  end

  // Grade
  logic [NUM_THR-1:0] thr_hit;
  logic [CODE_W-1:0]  level;

  feq_quant #(.FEAT_W(FEAT_W), .NUM_THR(NUM_THR), .CODE_W(CODE_W)) u_quant (
    .feat  (s1_feat),
    .thr   (thr_rd),
    .hit   (thr_hit),
    .level (level)
  );

  // Pack
  always_ff @(posedge clk) begin
    if (rst)           codes <= '0;
    else if (s1_valid) codes[s1_idx*CODE_W +: CODE_W] <= level;
  end

  // R3: the code vector only moves when a graded feature lands
  a_r3_codes_hold: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> $stable(codes));

  // R5: done rises right after the final position has been graded
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(s1_valid) && $past(s1_last)
                     && ($past(s1_idx) == IDX_W'(NUM_FEAT - 1))));

  // R2: a feature at or above the top threshold lands in the top level
  a_r2_top_level: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && thr_hit == '1) |=> (codes[$past(s1_idx)*CODE_W +: CODE_W] == CODE_W'(NUM_THR)));

endmodule

// File: tb/test_feat_level_encoder.sv
`timescale 1ns/1ps
module test_feat_level_encoder;

  localparam int NF   = 8;
  localparam int FW   = 6;
  localparam int AW   = 5;   // 3 index bits + 2 slot bits
  localparam int CW   = 2;

  logic            clk = 1'b0;
  logic            rst;
  logic            cfg_we;
  logic [AW-1:0]   cfg_addr;
  logic [FW-1:0]   cfg_thr;
  logic            feat_valid;
  logic [FW-1:0]   feat_data;
  logic            done;
  logic [NF*CW-1:0] codes;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int thr [NF][3];
  int vals [NF];

  always #10 clk = ~clk;  // 50 MHz

  feat_level_encoder #(.NUM_FEAT(NF), .FEAT_W(FW), .NUM_LVL(4)) i_feat_level_encoder (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_thr(cfg_thr),
    .feat_valid(feat_valid), .feat_data(feat_data), .done(done), .codes(codes)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference grading: thresholds per feature are kept non-decreasing here,
  // so a descending if-chain gives the level.
  function automatic int ref_level(input int f, input int v);
    if (v >= thr[f][2]) return 3;
    if (v >= thr[f][1]) return 2;
    if (v >= thr[f][0]) return 1;
    return 0;
  endfunction

  task automatic cfg_write(input int f, input int slot, input int v);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_addr = AW'(f * 4 + slot);
    cfg_thr  = FW'(v);
    @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  task automatic load_all();
    for (int f = 0; f < NF; f++)
      for (int k = 0; k < 3; k++) cfg_write(f, k, thr[f][k]);
  endtask

  // Send vals[], optionally with an idle cycle before each feature after the
  // first, optionally with a stray strobe in the drain cycle.
  task automatic send_image(input bit gaps, input bit poke, input string tag);
    for (int j = 0; j < NF; j++) begin
      if (gaps && j > 0) begin
        feat_valid = 1'b0;
        feat_data  = 6'h2a;
        @(negedge clk);
      end
      feat_valid = 1'b1;
      feat_data  = FW'(vals[j]);
      @(negedge clk);
      if (j == 0) check(done == 1'b0, "R6 done falls on first feature", done, 0);
    end
    // last feature accepted at the previous edge
    check(done == 1'b0, {"R5 done not yet after last accept ", tag}, done, 0);
    feat_valid = poke;
    feat_data  = 6'h15;
    @(negedge clk);
    check(done == 1'b1, {"R5 done one edge after last accept ", tag}, done, 1);
    feat_valid = 1'b0;
    if (poke) begin
      @(negedge clk);
      check(done == 1'b1, "R7 drain strobe leaves done high", done, 1);
    end
  endtask

  task automatic check_codes(input string req);
    for (int j = 0; j < NF; j++) begin
      int got;
      int exp;
      got = int'(codes[CW*j +: CW]);
      exp = ref_level(j, vals[j]);
      check(got == exp, req, got, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    thr[0] = '{-20, -20, -11};
    thr[1] = '{-32,  -5,  10};
    thr[2] = '{-10,   0,  12};
    thr[3] = '{ -4,  -4,  -4};
    thr[4] = '{  0,   5,  20};
    thr[5] = '{  3,   9,  14};
    thr[6] = '{-15,   8,  31};
    thr[7] = '{  1,   8,  17};

    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_thr = '0;
    feat_valid = 1'b0; feat_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1 done low after reset", done, 0);
    check(codes == '0, "R1 codes clear after reset", int'(codes), 0);

    load_all();

    // R2 R3 R8: every feature sees every value; odd images carry gaps
    for (int img = 0; img < 64; img++) begin
      for (int j = 0; j < NF; j++) vals[j] = ((img * 7 + j * 9) % 64) - 32;
      send_image(img[0], 1'b0, img[0] ? "R8 gapped" : "back-to-back");
      check_codes(img[0] ? "R8 R3 gapped codes" : "R2 R3 codes");
    end

    // R6: idle after done keeps flag and codes
    begin
      logic [NF*CW-1:0] held;
      held = codes;
      repeat (5) @(negedge clk);
      check(done == 1'b1, "R6 done held while idle", done, 1);
      check(codes == held, "R6 codes held while idle", int'(codes), int'(held));
    end

    // R7: stray strobe in the drain cycle must not shift the next image
    vals = '{0, -32, 12, -5, 19, 31, 30, 16};
    send_image(1'b0, 1'b1, "drain poke");
    check_codes("R7 image with drain strobe");
    vals = '{-11, 10, -1, -4, 4, 8, -16, 7};
    send_image(1'b0, 1'b0, "after poke");
    check_codes("R7 next image aligned");

    // R4: slot 3 writes change nothing
    cfg_write(0, 3, 31);
    cfg_write(3, 3, -32);
    cfg_write(6, 3, 0);
    vals = '{0, -6, 11, -4, 5, 9, 30, 8};
    send_image(1'b0, 1'b0, "slot3");
    check_codes("R4 unused slot ignored");

    // R9: rewrite thresholds between images
    thr[2] = '{20, 25, 30};
    thr[5] = '{-30, -29, -28};
    for (int k = 0; k < 3; k++) begin
      cfg_write(2, k, thr[2][k]);
      cfg_write(5, k, thr[5][k]);
    end
    vals = '{-21, 0, 22, 3, 20, -29, 31, 17};
    send_image(1'b1, 1'b0, "rewrite");
    check_codes("R9 rewritten thresholds apply");

    // R1: reset mid-life clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(done == 1'b0, "R1 done low after second reset", done, 0);
    check(codes == '0, "R1 codes clear after second reset", int'(codes), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule